// File: doc/BRIEF.md
# Processor Reset Sequencer with Cause Capture

This block generates power-on (POR) and externally initiated (XIR) reset pulses for a group of four processors. It also drives a system-wide reset. Software starts a pulse by writing a byte to one of two self-clearing control registers. Hardware requests also start a pulse: a watchdog, two push buttons, a debug port, a power-up detector, a clock-synthesizer update, a remote monitor and seven fatal-error lines. A small register port exposes control, presence and arbitration bits, plus two read-only cause registers. Each cause register records which requests started the most recent pulse of its kind.

Each reset kind is run by its own two-state sequencer. In `SEQ_IDLE`, any live cause takes the **START** transition: the full cause vector is captured in the same edge, and the sequencer moves to `SEQ_PULSE`. In `SEQ_PULSE`, the **HOLD** transition counts the pulse down. The **RELEASE** transition returns to `SEQ_IDLE` after exactly `PULSE_CYCLES` cycles and clears the software control bits. Requests raised while a pulse runs are not seen. Any cause other than a per-processor software bit makes the reset global: all processors are reset and, for POR, `sys_rst` is asserted.

Top module: `reset_cause_ctrl`

## Requirements
- R1: After `rst_n` is released, `por_out`, `xir_out`, `sys_rst` and `arb_en` are zero. Every register reads zero except the presence register.
- R2: Writing bits 0-3 to address 0 (soft POR) asserts `por_out` on exactly those processors, with `sys_rst` low. The pulse starts on the second rising edge after the write cycle.
- R3: Bit 4 at address 0 asserts all four `por_out` lines together with `sys_rst`. Every external POR cause in R6 also asserts all four `por_out` lines together with `sys_rst`. An external cause starts its pulse on the first edge at which it is seen high.
- R4: Writing bits 0-3 to address 1 (soft XIR) asserts `xir_out` on exactly those processors.
- R5: Address 2 bit 0 enables the watchdog. When it is set, a high `wdog_expire` starts a system POR and sets cause bit 16. When it is clear, `wdog_expire` produces no pulse and leaves the POR cause register unchanged.
- R6: The POR cause register is at address 6 and is read-only. Its bits are:
  - bits 0-3: per-processor soft reset
  - bit 4: soft system reset
  - bit 5: debug port
  - bit 6: reset button
  - bit 7: power-up
  - bits 8-14: fatal error from agents 0-6
  - bit 15: synthesizer update
  - bit 16: watchdog
  - bit 17: remote monitor

  At each pulse start, the register is overwritten with every cause live in that cycle.
- R7: While a pulse runs, new causes of the same kind are ignored. The cause register keeps its value and the pulse is not lengthened. A write to the soft register is dropped while its pulse is pending or active.
- R8: The XIR cause register is at address 7 and is read-only. Its bits are:
  - bits 0-3: soft XIR per processor
  - bit 4: `dbg_xir`
  - bit 5: `xir_button` or `wdog_xir`

  Bits 4 and 5 assert `xir_out` on all four processors.
- R9: Address 3 (quiesce) bits 4-7 mask fatal-error lines 0-3. A masked line neither starts a reset nor sets its cause bit. Lines 4-6 are never masked.
- R10: The soft registers read back their written bits until the pulse ends, then read zero.
- R11: Reserved bits are ignored on write and read as zero. These are:
  - address 0 bits 5-7
  - address 1 bits 4-7
  - address 2 bits 1-7
  - address 5 bits 4-7

  Address 4 returns `cpu_present` in bits 3:0. Address 5 bits 0-3 drive `arb_en`. Writes to addresses 4, 6 and 7 change nothing.
- R12: Every POR and XIR pulse lasts exactly `PULSE_CYCLES` clocks. Cause registers hold their value until the next pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low controller reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 3 | Read address |
| rd_data | output | DW | Read data, zero-extended |
| cpu_present | input | NCPU | Processor presence pins |
| wdog_expire | input | 1 | Watchdog expiry request (POR, gated) |
| wdog_xir | input | 1 | Watchdog XIR request |
| por_button | input | 1 | Reset push button |
| xir_button | input | 1 | XIR push button |
| dbg_por | input | 1 | Debug-port system reset request |
| dbg_xir | input | 1 | Debug-port XIR request |
| pwrup_det | input | 1 | Power-up detector |
| fatal_err | input | NAG | Fatal-error lines of agents 0..NAG-1 |
| synth_upd | input | 1 | Clock-synthesizer update reset request |
| remote_rst | input | 1 | Remote monitor reset request |
| por_out | output | NCPU | Per-processor POR pulse |
| xir_out | output | NCPU | Per-processor XIR pulse |
| sys_rst | output | 1 | System-wide reset |
| arb_en | output | NCPU | Per-processor arbitration enable |

## Verification
The bench aims at the capture edge. Two external causes raised in the same cycle must both appear in the cause register. A design that latched only one cause would lose a bit. A design that sampled a cycle late would record nothing, or would stretch the pulse. A request and a soft write are issued while a pulse runs. A sequencer that re-armed would produce a second pulse, and one that merged causes would corrupt the register. The bench also toggles a fatal line that is masked by quiesce and the watchdog while it is disabled. A wrong gate shows up there as an unexpected pulse seen by the monitor. Writes with reserved bits set are also checked. Sloppy masking would make those bits read back, or would turn a reserved bit into a spurious system reset.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    localparam int RCC_AW = 3;

    localparam logic [RCC_AW-1:0] ADDR_SOFT_POR = 3'd0;
    localparam logic [RCC_AW-1:0] ADDR_SOFT_XIR = 3'd1;
    localparam logic [RCC_AW-1:0] ADDR_WDOG     = 3'd2;
    localparam logic [RCC_AW-1:0] ADDR_QUIESCE  = 3'd3;
    localparam logic [RCC_AW-1:0] ADDR_PRESENT  = 3'd4;
    localparam logic [RCC_AW-1:0] ADDR_ARB      = 3'd5;
    localparam logic [RCC_AW-1:0] ADDR_POR_SRC  = 3'd6;
    localparam logic [RCC_AW-1:0] ADDR_XIR_SRC  = 3'd7;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_PULSE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/rcc_pulse_seq.sv
module rcc_pulse_seq #(
    parameter int CW           = 6,
    parameter int NLOCAL       = 4,
    parameter int PULSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     req,
    output logic              busy,
    output logic              finish,
    output logic [CW-1:0]     cause_q,
    output logic [NLOCAL-1:0] tgt
);
    import rcc_pkg::*;

    localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CW-1:0]    cause_d;

    // next-state: START / HOLD / RELEASE
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cause_d = cause_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (|req) begin
                    state_d = SEQ_PULSE;
                    cnt_d   = CNT_LOAD;
                    cause_d = req;
                end
            end
            SEQ_PULSE: begin
                if (cnt_q == '0) begin
                    state_d = SEQ_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cause_q <= cause_d;
        end
    end

    // outputs
    always_comb begin
        busy   = 1'b0;
        finish = 1'b0;
        tgt    = '0;
        unique case (state_q)
            SEQ_IDLE: begin
                busy = 1'b0;
            end
            SEQ_PULSE: begin
                busy   = 1'b1;
                finish = (cnt_q == '0);
                tgt    = (|cause_q[CW-1:NLOCAL]) ? '1 : cause_q[NLOCAL-1:0];
            end
        endcase
    end

endmodule

// File: rtl/rcc_regs.sv
module rcc_regs #(
    parameter int NCPU = 4,
    parameter int DW   = 32,
    parameter int PORW = 18,
    parameter int XIRW = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [rcc_pkg::RCC_AW-1:0] wr_addr,
    input  logic [7:0]               wr_data,
    input  logic [rcc_pkg::RCC_AW-1:0] rd_addr,
    output logic [DW-1:0]            rd_data,
    input  logic [NCPU-1:0]          cpu_present,
    input  logic                     por_busy,
    input  logic                     por_finish,
    input  logic                     xir_busy,
    input  logic                     xir_finish,
    input  logic [PORW-1:0]          por_src,
    input  logic [XIRW-1:0]          xir_src,
    output logic [NCPU:0]            soft_por,
    output logic [NCPU-1:0]          soft_xir,
    output logic                     wd_en,
    output logic [2*NCPU-1:0]        quiesce,
    output logic [NCPU-1:0]          arb_en
);
    import rcc_pkg::*;

    logic por_wr_ok, xir_wr_ok;

    assign por_wr_ok = wr_en && (wr_addr == ADDR_SOFT_POR) && !por_busy && (soft_por == '0);
    assign xir_wr_ok = wr_en && (wr_addr == ADDR_SOFT_XIR) && !xir_busy && (soft_xir == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_por <= '0;
            soft_xir <= '0;
            wd_en    <= 1'b0;
            quiesce  <= '0;
            arb_en   <= '0;
        end else begin
            if (por_finish)      soft_por <= '0;
            else if (por_wr_ok)  soft_por <= wr_data[NCPU:0];

            if (xir_finish)      soft_xir <= '0;
            else if (xir_wr_ok)  soft_xir <= wr_data[NCPU-1:0];

            if (wr_en) begin
                case (wr_addr)
                    ADDR_WDOG:    wd_en   <= wr_data[0];
                    ADDR_QUIESCE: quiesce <= wr_data[2*NCPU-1:0];
                    ADDR_ARB:     arb_en  <= wr_data[NCPU-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_SOFT_POR: rd_data = DW'(soft_por);
            ADDR_SOFT_XIR: rd_data = DW'(soft_xir);
            ADDR_WDOG:     rd_data = DW'(wd_en);
            ADDR_QUIESCE:  rd_data = DW'(quiesce);
            ADDR_PRESENT:  rd_data = DW'(cpu_present);
            ADDR_ARB:      rd_data = DW'(arb_en);
            ADDR_POR_SRC:  rd_data = DW'(por_src);
            ADDR_XIR_SRC:  rd_data = DW'(xir_src);
            default:       rd_data = '0;
        endcase
    end

endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl #(
    parameter int NCPU         = 4,
    parameter int NAG          = 7,
    parameter int PULSE_CYCLES = 4,
    parameter int DW           = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [rcc_pkg::RCC_AW-1:0] wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic [rcc_pkg::RCC_AW-1:0] rd_addr,
    output logic [DW-1:0]              rd_data,
    input  logic [NCPU-1:0]            cpu_present,
    input  logic                       wdog_expire,
    input  logic                       wdog_xir,
    input  logic                       por_button,
    input  logic                       xir_button,
    input  logic                       dbg_por,
    input  logic                       dbg_xir,
    input  logic                       pwrup_det,
    input  logic [NAG-1:0]             fatal_err,
    input  logic                       synth_upd,
    input  logic                       remote_rst,
    output logic [NCPU-1:0]            por_out,
    output logic [NCPU-1:0]            xir_out,
    output logic                       sys_rst,
    output logic [NCPU-1:0]            arb_en
);
    // POR cause: cpu[NCPU] sys dbg btn pwr fatal[NAG] synth wdog remote
    localparam int PORW = NCPU + 4 + NAG + 3;
    // XIR cause: cpu[NCPU] dbg btn_or_wdog
    localparam int XIRW = NCPU + 2;

    logic [NCPU:0]       soft_por_q;
    logic [NCPU-1:0]     soft_xir_q;
    logic                wd_en_q;
    logic [2*NCPU-1:0]   quiesce_q;
    logic [NAG-1:0]      fe_live;
    logic [PORW-1:0]     por_req, por_src_q;
    logic [XIRW-1:0]     xir_req, xir_src_q;
    logic                por_busy, por_finish, xir_busy, xir_finish;

    genvar g;
    generate
        for (g = 0; g < NAG; g++) begin : g_fe
            if (g < NCPU) begin : g_masked
                assign fe_live[g] = fatal_err[g] & ~quiesce_q[NCPU+g];
            end else begin : g_open
                assign fe_live[g] = fatal_err[g];
            end
        end
    endgenerate

    assign por_req = {remote_rst, wdog_expire & wd_en_q, synth_upd, fe_live,
                      pwrup_det, por_button, dbg_por, soft_por_q};
    assign xir_req = {xir_button | wdog_xir, dbg_xir, soft_xir_q};

    rcc_regs #(
        .NCPU(NCPU), .DW(DW), .PORW(PORW), .XIRW(XIRW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .cpu_present(cpu_present),
        .por_busy(por_busy), .por_finish(por_finish),
        .xir_busy(xir_busy), .xir_finish(xir_finish),
        .por_src(por_src_q), .xir_src(xir_src_q),
        .soft_por(soft_por_q), .soft_xir(soft_xir_q),
        .wd_en(wd_en_q), .quiesce(quiesce_q), .arb_en(arb_en)
    );

    rcc_pulse_seq #(
        .CW(PORW), .NLOCAL(NCPU), .PULSE_CYCLES(PULSE_CYCLES)
    ) u_por (
        .clk(clk), .rst_n(rst_n), .req(por_req),
        .busy(por_busy), .finish(por_finish),
        .cause_q(por_src_q), .tgt(por_out)
    );

    rcc_pulse_seq #(
        .CW(XIRW), .NLOCAL(NCPU), .PULSE_CYCLES(PULSE_CYCLES)
    ) u_xir (
        .clk(clk), .rst_n(rst_n), .req(xir_req),
        .busy(xir_busy), .finish(xir_finish),
        .cause_q(xir_src_q), .tgt(xir_out)
    );

    assign sys_rst = por_busy && (|por_src_q[PORW-1:NCPU]);

endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
    parameter int NCPU         = 4,
    parameter int NAG          = 7,
    parameter int PULSE_CYCLES = 4,
    parameter int PORW         = 18,
    parameter int XIRW         = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCPU-1:0]   por_out,
    input logic [NCPU-1:0]   xir_out,
    input logic              sys_rst,
    input logic [PORW-1:0]   por_src,
    input logic [XIRW-1:0]   xir_src,
    input logic              wd_en,
    input logic [2*NCPU-1:0] quiesce
);
    localparam int FE0_BIT = NCPU + 4;
    localparam int WDT_BIT = NCPU + 4 + NAG + 1;

    int por_cnt, xir_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            por_cnt <= 0;
            xir_cnt <= 0;
        end else begin
            por_cnt <= (|por_out) ? por_cnt + 1 : 0;
            xir_cnt <= (|xir_out) ? xir_cnt + 1 : 0;
        end
    end

    assert_sys_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (&por_out));

    assert_local_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|por_out) && !sys_rst) |-> (por_out == por_src[NCPU-1:0]));

    assert_por_max_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|por_out) |-> (por_cnt < PULSE_CYCLES));

    assert_por_len_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|por_out) |-> ($past(por_cnt) == PULSE_CYCLES - 1));

    assert_xir_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|xir_out) |-> (xir_cnt < PULSE_CYCLES));

    assert_xir_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|xir_out) |-> ($past(xir_cnt) == PULSE_CYCLES - 1));

    assert_por_src_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|por_out) && $past(|por_out)) |-> $stable(por_src));

    assert_xir_src_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|xir_out) && $past(|xir_out)) |-> $stable(xir_src));

    assert_wdog_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_src[WDT_BIT]) |-> $past(wd_en));

    assert_quiesce_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_src[FE0_BIT]) |-> !$past(quiesce[NCPU]));

endmodule

bind reset_cause_ctrl rcc_checker #(
    .NCPU(NCPU), .NAG(NAG), .PULSE_CYCLES(PULSE_CYCLES),
    .PORW(NCPU + 4 + NAG + 3), .XIRW(NCPU + 2)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .por_out(por_out), .xir_out(xir_out), .sys_rst(sys_rst),
    .por_src(por_src_q), .xir_src(xir_src_q),
    .wd_en(wd_en_q), .quiesce(quiesce_q)
);

// File: tb/reset_cause_ctrl_test.sv
module reset_cause_ctrl_test;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  cpu_present = 4'b1011;
    logic [8:0]  ext = '0;
    logic [6:0]  fe = '0;
    logic [3:0]  por_out, xir_out, arb_en;
    logic        sys_rst;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct { logic [3:0] mask; logic sys; string tag; } exp_t;
    exp_t por_q[$];
    exp_t xir_q[$];

    reset_cause_ctrl #(.PULSE_CYCLES(P)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .cpu_present(cpu_present),
        .wdog_expire(ext[0]), .wdog_xir(ext[1]),
        .por_button(ext[2]), .xir_button(ext[3]),
        .dbg_por(ext[4]), .dbg_xir(ext[5]),
        .pwrup_det(ext[6]), .fatal_err(fe),
        .synth_upd(ext[7]), .remote_rst(ext[8]),
        .por_out(por_out), .xir_out(xir_out),
        .sys_rst(sys_rst), .arb_en(arb_en)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_por(input logic [3:0] m, input logic s, input string tag);
        exp_t e;
        e.mask = m; e.sys = s; e.tag = tag;
        por_q.push_back(e);
    endtask

    task automatic expect_xir(input logic [3:0] m, input string tag);
        exp_t e;
        e.mask = m; e.sys = 1'b0; e.tag = tag;
        xir_q.push_back(e);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp,
                          input string req, input string what);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(rd_data == exp, req, what, rd_data, exp);
    endtask

    task automatic strobe(input logic [8:0] e, input logic [6:0] f);
        @(negedge clk);
        ext = e; fe = f;
        @(negedge clk);
        ext = '0; fe = '0;
    endtask

    task automatic wait_idle();
        repeat (P + 3) @(negedge clk);
    endtask

    // POR monitor
    bit         p_act = 0;
    int         p_len = 0;
    logic [3:0] p_mask;
    logic       p_sys;
    always @(negedge clk) begin
        if (rst_n) begin
            if (por_out != 0) begin
                if (!p_act) begin
                    p_act = 1; p_mask = por_out; p_sys = sys_rst; p_len = 0;
                end
                p_len++;
            end else if (p_act) begin
                exp_t e;
                p_act = 0;
                if (por_q.size() == 0) begin
                    check(0, "R7", "unexpected POR pulse", 32'(p_mask), 0);
                end else begin
                    e = por_q.pop_front();
                    check(p_mask == e.mask, e.tag, "POR mask", 32'(p_mask), 32'(e.mask));
                    check(p_sys == e.sys, e.tag, "sys_rst", 32'(p_sys), 32'(e.sys));
                    check(p_len == P, "R12", "POR length", 32'(p_len), 32'(P));
                end
            end
        end
    end

    // XIR monitor
    bit         x_act = 0;
    int         x_len = 0;
    logic [3:0] x_mask;
    always @(negedge clk) begin
        if (rst_n) begin
            if (xir_out != 0) begin
                if (!x_act) begin
                    x_act = 1; x_mask = xir_out; x_len = 0;
                end
                x_len++;
            end else if (x_act) begin
                exp_t e;
                x_act = 0;
                if (xir_q.size() == 0) begin
                    check(0, "R7", "unexpected XIR pulse", 32'(x_mask), 0);
                end else begin
                    e = xir_q.pop_front();
                    check(x_mask == e.mask, e.tag, "XIR mask", 32'(x_mask), 32'(e.mask));
                    check(x_len == P, "R12", "XIR length", 32'(x_len), 32'(P));
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(por_out == 0 && xir_out == 0, "R1", "pulses after reset", 32'({por_out, xir_out}), 0);
        check(sys_rst == 0, "R1", "sys_rst after reset", 32'(sys_rst), 0);
        check(arb_en == 0, "R1", "arb_en after reset", 32'(arb_en), 0);
        rd_chk(3'd6, 0, "R1", "POR cause after reset");
        rd_chk(3'd7, 0, "R1", "XIR cause after reset");
        rd_chk(3'd3, 0, "R1", "quiesce after reset");
        rd_chk(3'd4, 32'h0B, "R11", "presence pins");

        // R2 per-processor soft POR, R10 readback
        expect_por(4'b0101, 1'b0, "R2");
        wr(3'd0, 8'h05);
        rd_chk(3'd0, 32'h05, "R10", "soft POR pending");
        wait_idle();
        rd_chk(3'd0, 0, "R10", "soft POR self-clear");
        rd_chk(3'd6, 32'h05, "R6", "cause soft cpu0/2");

        // R3 soft system reset, reserved bits 5-7 ignored (R11)
        expect_por(4'hF, 1'b1, "R3");
        wr(3'd0, 8'hF0);
        rd_chk(3'd0, 32'h10, "R11", "soft POR reserved bits");
        wait_idle();
        rd_chk(3'd6, 32'h10, "R6", "cause soft system");

        // R4 soft XIR
        expect_xir(4'b1010, "R4");
        wr(3'd1, 8'hFA);
        rd_chk(3'd1, 32'h0A, "R10", "soft XIR pending, reserved dropped");
        wait_idle();
        rd_chk(3'd1, 0, "R10", "soft XIR self-clear");
        rd_chk(3'd7, 32'h0A, "R8", "XIR cause soft");

        // R5 watchdog disabled: ignored
        strobe(9'h001, 7'h00);
        wait_idle();
        rd_chk(3'd6, 32'h10, "R5", "cause unchanged, watchdog off");

        // R5 watchdog enabled
        wr(3'd2, 8'hFF);
        rd_chk(3'd2, 32'h01, "R11", "wdog reg reserved bits");
        expect_por(4'hF, 1'b1, "R5");
        strobe(9'h001, 7'h00);
        wait_idle();
        rd_chk(3'd6, 32'h10000, "R5", "cause watchdog");

        // R6 two causes in the same cycle: debug + button
        expect_por(4'hF, 1'b1, "R6");
        strobe(9'h014, 7'h00);
        wait_idle();
        rd_chk(3'd6, 32'h60, "R6", "cause debug+button");

        // R7 causes during a pulse are ignored
        expect_por(4'hF, 1'b1, "R7");
        strobe(9'h040, 7'h00);
        strobe(9'h100, 7'h00);
        wr(3'd0, 8'h01);
        wait_idle();
        rd_chk(3'd6, 32'h80, "R7", "cause power-up only");
        rd_chk(3'd0, 0, "R7", "soft write dropped during pulse");

        // R9 quiesce masks fatal 0
        wr(3'd3, 8'h10);
        rd_chk(3'd3, 32'h10, "R9", "quiesce readback");
        strobe(9'h000, 7'h01);
        wait_idle();
        rd_chk(3'd6, 32'h80, "R9", "masked fatal leaves cause");
        expect_por(4'hF, 1'b1, "R9");
        strobe(9'h000, 7'h02);
        wait_idle();
        rd_chk(3'd6, 32'h200, "R9", "cause fatal agent1");
        expect_por(4'hF, 1'b1, "R6");
        strobe(9'h080, 7'h20);
        wait_idle();
        rd_chk(3'd6, 32'hA000, "R6", "cause fatal agent5 + synth");
        expect_por(4'hF, 1'b1, "R6");
        strobe(9'h100, 7'h00);
        wait_idle();
        rd_chk(3'd6, 32'h20000, "R6", "cause remote");

        // R8 external XIR to all processors
        expect_xir(4'hF, "R8");
        strobe(9'h020, 7'h00);
        wait_idle();
        rd_chk(3'd7, 32'h10, "R8", "XIR cause debug");
        expect_xir(4'hF, "R8");
        strobe(9'h008, 7'h00);
        wait_idle();
        rd_chk(3'd7, 32'h20, "R8", "XIR cause button");
        expect_xir(4'hF, "R8");
        strobe(9'h002, 7'h00);
        wait_idle();
        rd_chk(3'd7, 32'h20, "R8", "XIR cause watchdog");

        // R11 arbitration and read-only addresses
        wr(3'd5, 8'hFF);
        check(arb_en == 4'hF, "R11", "arb_en output", 32'(arb_en), 32'hF);
        rd_chk(3'd5, 32'h0F, "R11", "arb reserved bits");
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        wr(3'd4, 8'h00);
        rd_chk(3'd6, 32'h20000, "R11", "POR cause read-only");
        rd_chk(3'd7, 32'h20, "R11", "XIR cause read-only");
        rd_chk(3'd4, 32'h0B, "R11", "presence read-only");

        wait_idle();
        check(por_q.size() == 0, "R12", "POR pulses missing", 32'(por_q.size()), 0);
        check(xir_q.size() == 0, "R12", "XIR pulses missing", 32'(xir_q.size()), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule